// File: doc/BRIEF.md
# Radio Event Timestamp Capture Unit

This block records the local time at three events. The first is the radio's transmit mark. The second is the radio's receive mark. Both marks fall at the point where a frame's preamble ends and its payload begins. The third is a rising edge on an external reference pulse, which arrives roughly once a second and is used only to measure clock accuracy.

The capture point sits below the medium-access layer. Waiting for the medium therefore never adds error to a stamp. A frame that is sent again is stamped again, and the new stamp replaces the old one. The delays between a mark and the stamp are a fixed number of cycles, so software treats them as a constant.

Each event input is asynchronous. It passes through a synchroniser, and a rising-edge detector then raises a one-cycle capture strobe. The 64-bit time input carries seconds in bits 63:32 and nanoseconds in bits 31:0. On a capture strobe the whole 64-bit word is latched in one cycle. A processor reads a stamp and then acknowledges it per channel. Each channel has a valid flag and an overrun flag. Channel index 0 is transmit, index 1 is receive and index 2 is the reference pulse.

Top module: `rfstamp_capture`

## Requirements
- R1: While `rstN` is low, every stamp, valid flag and overrun flag reads zero.
- R2: Channel 0 (transmit mark) works as follows. If `evtIn[0]` rises before clock edge k, `stampOut[0]` takes the `timeNow` value present at edge k+2.
- R3: Channel 1 (receive mark) follows the same timing as R2, driven by `evtIn[1]` into `stampOut[1]`.
- R4: Channel 2 (reference pulse) follows the same timing as R2, driven by `evtIn[2]` into `stampOut[2]`. It runs independently of the other two channels.
- R5: Exactly one capture happens for each rising edge. A strobe held high causes no further capture.
- R6: The seconds and nanoseconds words of a stamp always come from the same clock edge, including across a nanosecond rollover.
- R7: A new capture on a channel replaces that channel's earlier stamp. Between captures the stamp holds its value.
- R8: A channel's valid flag works as follows.
  - A capture sets it.
  - A high `ackIn[c]` with no capture in the same cycle clears it.
  - A capture in the same cycle as an acknowledge leaves it set.
- R9: A channel's overrun flag works as follows.
  - It is set when a capture arrives while the valid flag is set and the channel is not being acknowledged.
  - It stays set until an acknowledge.
  - An acknowledge clears it.
- R10: An acknowledge on a channel leaves that channel's stamp unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| timeNow | input | 64 | Local time; seconds in 63:32, nanoseconds in 31:0 |
| evtIn | input | 3 | Asynchronous event strobes: 0 transmit, 1 receive, 2 reference |
| ackIn | input | 3 | Per-channel read acknowledge |
| stampOut | output | 3x64 | Captured time per channel |
| validOut | output | 3 | Stamp waiting to be read, per channel |
| overrunOut | output | 3 | Unread stamp was replaced, per channel |

## Verification
The bench targets the following corner cases:
- A strobe held high for many cycles. A detector that is level-sensitive would keep re-stamping and fail R5.
- A capture that lands exactly on a nanosecond rollover. Latching the two words on different edges would produce a stamp a whole second off.
- An acknowledge in the same cycle as a fresh capture. Getting the priority wrong would lose the new stamp's valid flag.
- Back-to-back captures with no read. A missing overrun flag would hide the lost stamp.
- An acknowledge on a channel that holds nothing. A design that clears the stamp here would corrupt the value.

// File: rtl/rfstamp_pkg.sv
package rfstamp_pkg;
  localparam int NCH    = 3;
  localparam int CH_TX  = 0;
  localparam int CH_RX  = 1;
  localparam int CH_REF = 2;

  typedef struct packed {
    logic [NCH-1:0] capture;
  } stampCtl_t;
endpackage

// File: rtl/rfstamp_ctrl.sv
module rfstamp_ctrl
  import rfstamp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NCH-1:0] evtIn,
  input  logic [NCH-1:0] ackIn,
  output stampCtl_t      ctl,
  output logic [NCH-1:0] validOut,
  output logic [NCH-1:0] overrunOut
);
  localparam int SHW = SYNC_STAGES + 1;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SHW-1:0] syncQ;

    // Synchroniser stages, plus one extra stage used for edge detection.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ <= '0;
      else       syncQ <= {syncQ[SHW-2:0], evtIn[c]};
    end

    assign ctl.capture[c] = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validOut[c]   <= 1'b0;
        overrunOut[c] <= 1'b0;
      end else begin
        validOut[c] <= ctl.capture[c] | (validOut[c] & ~ackIn[c]);
        if (ackIn[c])
          overrunOut[c] <= 1'b0;
        else if (ctl.capture[c] && validOut[c])
          overrunOut[c] <= 1'b1;
      end
    end

    assert_valid_on_capture_R8: assert property (@(posedge clk) disable iff (!rstN)
      ctl.capture[c] |=> validOut[c]);
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
      (ackIn[c] && !ctl.capture[c]) |=> !validOut[c]);
    assert_overrun_set_R9: assert property (@(posedge clk) disable iff (!rstN)
      (ctl.capture[c] && validOut[c] && !ackIn[c]) |=> overrunOut[c]);
    assert_one_capture_R5: assert property (@(posedge clk) disable iff (!rstN)
      ctl.capture[c] |=> !ctl.capture[c]);
  end
endmodule

// File: rtl/rfstamp_dpath.sv
module rfstamp_dpath
  import rfstamp_pkg::*;
#(
  parameter int TIME_W = 64
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [TIME_W-1:0]         timeNow,
  input  stampCtl_t                 ctl,
  output logic [NCH-1:0][TIME_W-1:0] stampOut
);
  for (genvar c = 0; c < NCH; c++) begin : g_reg
    // The full time word is loaded in one register, so both halves come from one edge.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               stampOut[c] <= '0;
      else if (ctl.capture[c]) stampOut[c] <= timeNow;
    end

    assert_capture_word_R6: assert property (@(posedge clk) disable iff (!rstN)
      ctl.capture[c] |=> (stampOut[c] == $past(timeNow)));
    assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rstN)
      !ctl.capture[c] |=> $stable(stampOut[c]));
  end
endmodule

// File: rtl/rfstamp_capture.sv
module rfstamp_capture
  import rfstamp_pkg::*;
#(
  parameter int TIME_W      = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [TIME_W-1:0]          timeNow,
  input  logic [NCH-1:0]             evtIn,
  input  logic [NCH-1:0]             ackIn,
  output logic [NCH-1:0][TIME_W-1:0] stampOut,
  output logic [NCH-1:0]             validOut,
  output logic [NCH-1:0]             overrunOut
);
  stampCtl_t ctl;

  rfstamp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .ackIn(ackIn),
    .ctl(ctl), .validOut(validOut), .overrunOut(overrunOut)
  );

  rfstamp_dpath #(.TIME_W(TIME_W)) u_dpath (
    .clk(clk), .rstN(rstN), .timeNow(timeNow), .ctl(ctl), .stampOut(stampOut)
  );
endmodule

// File: tb/rfstamp_capture_test.sv
module rfstamp_capture_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rstN;
  logic [63:0]      timeNow;
  logic [2:0]       evtIn, ackIn;
  logic [2:0][63:0] stampOut;
  logic [2:0]       validOut, overrunOut;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  bit modelOn = 0;
  logic [31:0] secNow, nsNow;

  // Reference model state
  logic [63:0] mStamp [3];
  bit mValid [3];
  bit mOver  [3];
  bit hist   [3][3];   // [0] newest sample of the strobe

  rfstamp_capture uut (
    .clk(clk), .rstN(rstN), .timeNow(timeNow), .evtIn(evtIn), .ackIn(ackIn),
    .stampOut(stampOut), .validOut(validOut), .overrunOut(overrunOut)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    nsNow = nsNow + 32'd10;
    if (nsNow >= 32'd1000000000) begin
      nsNow  = nsNow - 32'd1000000000;
      secNow = secNow + 32'd1;
    end
    timeNow = {secNow, nsNow};
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse(int c, int len);
    evtIn[c] = 1'b1;
    wait_n(len);
    evtIn[c] = 1'b0;
  endtask

  // Behavioural model: a rising edge is seen two samples late; the flags follow R8 and R9.
  always @(posedge clk) begin
    for (int c = 0; c < 3; c++) begin
      if (!rstN) begin
        mStamp[c] = '0; mValid[c] = 0; mOver[c] = 0;
        for (int k = 0; k < 3; k++) hist[c][k] = 0;
      end else begin
        bit edgeNow;
        edgeNow = hist[c][1] && !hist[c][2];
        hist[c][2] = hist[c][1];
        hist[c][1] = hist[c][0];
        hist[c][0] = evtIn[c];
        if (ackIn[c]) mOver[c] = 0;
        else if (edgeNow && mValid[c]) mOver[c] = 1;
        if (edgeNow) begin
          mStamp[c] = timeNow;
          mValid[c] = 1;
        end else if (ackIn[c]) begin
          mValid[c] = 0;
        end
      end
    end
  end

  // Compare every cycle, half a period after the edge.
  always @(negedge clk) begin
    if (modelOn && rstN) begin
      chk("R2 tx stamp",  stampOut[0], mStamp[0]);
      chk("R3 rx stamp",  stampOut[1], mStamp[1]);
      chk("R4 ref stamp", stampOut[2], mStamp[2]);
      for (int c = 0; c < 3; c++) begin
        chk("R8 valid",   {63'd0, validOut[c]},   {63'd0, mValid[c]});
        chk("R9 overrun", {63'd0, overrunOut[c]}, {63'd0, mOver[c]});
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    rstN = 1'b0; evtIn = '0; ackIn = '0;
    secNow = 32'd5; nsNow = 32'd0; timeNow = {secNow, nsNow};
    wait_n(4);
    // R1: everything is zero while reset is held
    for (int c = 0; c < 3; c++) begin
      chk("R1 stamp reset", stampOut[c], 64'd0);
      chk("R1 valid reset", {63'd0, validOut[c]}, 64'd0);
      chk("R1 overrun reset", {63'd0, overrunOut[c]}, 64'd0);
    end
    rstN = 1'b1; modelOn = 1;
    wait_n(3);

    // R2: transmit mark
    pulse(0, 2); wait_n(6);
    chk("R2 tx valid", {63'd0, validOut[0]}, 64'd1);
    // R3: receive mark
    pulse(1, 1); wait_n(6);
    chk("R3 rx valid", {63'd0, validOut[1]}, 64'd1);
    // R4: reference pulse, alone
    pulse(2, 3); wait_n(6);
    chk("R4 ref valid", {63'd0, validOut[2]}, 64'd1);

    // R5: a long high strobe captures only once
    evtIn[0] = 1'b1; wait_n(5);
    held = stampOut[0];
    wait_n(30);
    chk("R5 held strobe no recapture", stampOut[0], held);
    evtIn[0] = 1'b0; wait_n(4);
    // R9: tx was captured twice with no read
    chk("R9 overrun after unread", {63'd0, overrunOut[0]}, 64'd1);

    // R8/R9: acknowledge everything
    ackIn = 3'b111; tick(); ackIn = '0; tick();
    chk("R8 ack clears valid", {61'd0, validOut}, 64'd0);
    chk("R9 ack clears overrun", {61'd0, overrunOut}, 64'd0);

    // R7: a retransmission replaces the earlier stamp
    pulse(0, 1); wait_n(5);
    held = stampOut[0];
    pulse(0, 1); wait_n(5);
    chk("R7 new stamp replaced old", {63'd0, stampOut[0] != held}, 64'd1);

    // R10: acknowledge on an empty channel keeps the stamp
    held = stampOut[1];
    ackIn[1] = 1'b1; tick(); ackIn[1] = 1'b0; wait_n(2);
    chk("R10 ack keeps stamp", stampOut[1], held);

    // R6: capture lands exactly on a nanosecond rollover
    ackIn = 3'b111; tick(); ackIn = '0;
    tick();
    secNow = 32'd7; nsNow = 32'd999999980; timeNow = {secNow, nsNow};
    evtIn[1] = 1'b1;
    tick(); tick(); tick();
    evtIn[1] = 1'b0;
    chk("R6 rollover stamp", stampOut[1], {32'd8, 32'd0});

    // R8/R9: capture while acknowledge is held high
    ackIn[2] = 1'b1;
    pulse(2, 2); wait_n(5);
    chk("R9 no overrun under ack", {63'd0, overrunOut[2]}, 64'd0);
    ackIn[2] = 1'b0; wait_n(2);

    // All three channels at once
    evtIn = 3'b111; wait_n(2); evtIn = '0; wait_n(5);
    chk("R4 simultaneous valid", {61'd0, validOut}, 64'd7);
    pulse(1, 1); pulse(1, 1); wait_n(6);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule